// File: doc/BRIEF.md
# ATA Device Identification Probe Controller

This block runs the discovery handshake for one position on a parallel ATA bus and reports what kind of device sits there. A single `start` pulse makes it select the drive, issue the IDENTIFY command and follow the device's status replies through a simple task-file register bus. That bus carries a 3-bit register index, separate read and write strobes, and 16-bit data in each direction. When it has finished, the block emits a one-cycle `done` pulse together with a classification code.

The code tells no device, plain ATA disk, packet-interface (ATAPI) device, serial (SATA) device, or failure. When a plain ATA disk answers with data, the block reads the whole 256-word identify block. From it, the block keeps the 28-bit addressable sector count, the 48-bit addressable sector count and the 48-bit addressing feature flag. The classification is based on the signature bytes the device leaves in its LBA mid and LBA high registers, and not on the error flag alone. Each wait loop is bounded by a host-supplied limit on the number of status reads.

Top module: `ata_probe_ctrl`

## Requirements
- R1: A `start` accepted while idle produces exactly two writes, in this order. The first is to index 6 with data `0x00A0 | drive_sel<<4`. The second is to index 7 with data `0x00EC`. The first read after them is of index 7. No cycle ever has both strobes high. Read data is taken from `rd_data` one cycle after the read strobe.
- R2: If that first status read returns 0 in its low byte, the result is none (code 0). No further bus access follows before `done`.
- R3: Otherwise the block reads index 7 repeatedly while bit 7 (busy) is set. It moves on at the first read that shows busy clear.
- R4: After busy clears, the block reads index 4 (LBA mid), then index 5 (LBA high). If either low byte is non-zero, it reads no more status and no data. It reports packet device (code 2) for 0x14/0xEB, serial device (code 3) for 0x3C/0xC3, and failure (code 4) for any other non-zero pair. The status error bit plays no part in this decision.
- R5: With both signature bytes zero, the block polls index 7 until bit 3 (data request) or bit 0 (error) is set. The error bit gives failure (code 4), even when the data request bit is also set.
- R6: A status read with the data request bit set and the error bit clear is followed by exactly 256 reads of index 0. The result is ATA disk (code 1).
- R7: `lba28_sectors` holds word 61 (high half) and word 60 (low half) of the identify block. `lba28_ok` is high when that value is non-zero.
- R8: `lba48_ok` equals bit 10 of word 83. `lba48_sectors` holds words 100 to 103, with word 100 as the least significant.
- R9: In each wait loop (busy, then data request), the result is failure once the `timeout_lim`-th status read of that loop still shows the condition pending. A value of 0 acts as 1. A wait that resolves on exactly that read is not a failure.
- R10: `done` lasts one cycle, and no strobe is active in that cycle. `result` changes only in the `done` cycle. The three identify fields are cleared when a run starts, so they read zero after any result other than ATA disk.
- R11: After reset, `done`, `result`, both strobes and all identify fields are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a probe (taken only while idle) |
| drive_sel | input | 1 | Drive position written into the drive-select register |
| timeout_lim | input | 16 | Status reads allowed per wait loop |
| reg_idx | output | 3 | Task-file register index |
| rd_stb | output | 1 | Register read strobe |
| wr_stb | output | 1 | Register write strobe |
| wr_data | output | 16 | Register write data |
| rd_data | input | 16 | Register read data, valid the cycle after `rd_stb` |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 none, 1 ATA, 2 packet, 3 serial, 4 failure |
| lba28_ok | output | 1 | 28-bit sector count is non-zero |
| lba28_sectors | output | 32 | Sector count from words 60/61 |
| lba48_ok | output | 1 | Word 83 bit 10 |
| lba48_sectors | output | 64 | Sector count from words 100..103 |

## Verification
The expiry of the wait limit and the status read that ends the wait can fall on the same read. When they coincide, the block must treat the wait as satisfied. The bench provokes this by giving the device model a busy count, or a data-request delay, equal to the limit, and then one more than the limit. It judges the outcome from the result code and from the number of status reads the model saw. Random runs across all device kinds and limits also land on this boundary.

// File: rtl/ata_probe_pkg.sv
package ata_probe_pkg;

  localparam int DATA_W   = 16;
  localparam int IDX_W    = 3;
  localparam int ID_WORDS = 256;
  localparam int WIDX_W   = $clog2(ID_WORDS);

  localparam logic [IDX_W-1:0] RIX_DATA   = 3'd0;
  localparam logic [IDX_W-1:0] RIX_SIGMID = 3'd4;
  localparam logic [IDX_W-1:0] RIX_SIGHI  = 3'd5;
  localparam logic [IDX_W-1:0] RIX_DRVSEL = 3'd6;
  localparam logic [IDX_W-1:0] RIX_CMDST  = 3'd7;

  localparam logic [7:0] CMD_IDENT   = 8'hEC;
  localparam logic [7:0] DRVSEL_BASE = 8'hA0;

  localparam int STB_BUSY = 7;
  localparam int STB_DREQ = 3;
  localparam int STB_FAIL = 0;

  localparam logic [7:0] SIG_PKT_MID = 8'h14;
  localparam logic [7:0] SIG_PKT_HI  = 8'hEB;
  localparam logic [7:0] SIG_SER_MID = 8'h3C;
  localparam logic [7:0] SIG_SER_HI  = 8'hC3;

  localparam int W28_BASE  = 60;
  localparam int W28_CNT   = 2;
  localparam int W48_BASE  = 100;
  localparam int W48_CNT   = 4;
  localparam int WFEAT     = 83;
  localparam int FEAT_BIT  = 10;

  typedef enum logic [2:0] {
    RES_NONE = 3'd0,
    RES_ATA  = 3'd1,
    RES_PKT  = 3'd2,
    RES_SER  = 3'd3,
    RES_FAIL = 3'd4
  } probe_res_e;

  typedef enum logic [3:0] {
    PS_IDLE, PS_WSEL, PS_WCMD, PS_RST0, PS_CST0,
    PS_RBSY, PS_CBSY, PS_RMID, PS_CMID, PS_RHI, PS_CHI,
    PS_RDRQ, PS_CDRQ, PS_RDAT, PS_CDAT
  } probe_st_e;

endpackage

// File: rtl/ata_probe_rstsync.sv
module ata_probe_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ata_probe_timer.sv
module ata_probe_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pend,
  input  logic [CW-1:0] lim,
  output logic          expire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   cnt_inc;
  logic          cnt_en;

  assign cnt_inc = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  // the pending read that brings the count up to the limit is the last one allowed
  assign expire  = pend && (cnt_inc >= {1'b0, lim});
  assign cnt_en  = clr || (pend && !expire);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (pend && !expire) cnt_d = cnt_inc[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ata_probe_idcap.sv
module ata_probe_idcap
  import ata_probe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                cap_en,
  input  logic [WIDX_W-1:0]   cap_idx,
  input  logic [DATA_W-1:0]   cap_word,
  output logic                lba28_ok,
  output logic [W28_CNT*DATA_W-1:0] lba28_sectors,
  output logic                lba48_ok,
  output logic [W48_CNT*DATA_W-1:0] lba48_sectors
);
  logic feat_q;

  genvar g;
  generate
    for (g = 0; g < W28_CNT; g++) begin : g_w28
      logic [DATA_W-1:0] w_q;
      logic              w_en;
      assign w_en = clr || (cap_en && (cap_idx == WIDX_W'(W28_BASE + g)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    w_q <= '0;
        else if (w_en) w_q <= clr ? '0 : cap_word;
      end
      assign lba28_sectors[g*DATA_W +: DATA_W] = w_q;
    end
    for (g = 0; g < W48_CNT; g++) begin : g_w48
      logic [DATA_W-1:0] w_q;
      logic              w_en;
      assign w_en = clr || (cap_en && (cap_idx == WIDX_W'(W48_BASE + g)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    w_q <= '0;
        else if (w_en) w_q <= clr ? '0 : cap_word;
      end
      assign lba48_sectors[g*DATA_W +: DATA_W] = w_q;
    end
  endgenerate

  logic feat_en;
  assign feat_en = clr || (cap_en && (cap_idx == WIDX_W'(WFEAT)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       feat_q <= 1'b0;
    else if (feat_en) feat_q <= clr ? 1'b0 : cap_word[FEAT_BIT];
  end

  assign lba48_ok = feat_q;
  assign lba28_ok = |lba28_sectors;
endmodule

// File: rtl/ata_probe_seq.sv
module ata_probe_seq
  import ata_probe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                drive_sel,
  input  logic [DATA_W-1:0]   rd_data,
  output logic [IDX_W-1:0]    reg_idx,
  output logic                rd_stb,
  output logic                wr_stb,
  output logic [DATA_W-1:0]   wr_data,
  output logic                tmr_clr,
  output logic                tmr_pend,
  input  logic                tmr_expire,
  output logic                cap_clr,
  output logic                cap_en,
  output logic [WIDX_W-1:0]   cap_idx,
  output logic                done,
  output logic [2:0]          result
);
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(ID_WORDS - 1);

  probe_st_e          st_q, st_d;
  probe_res_e         res_q, res_d;
  logic               done_q, done_d;
  logic [WIDX_W-1:0]  wcnt_q, wcnt_d;
  logic [7:0]         mid_q, mid_d;
  logic [7:0]         rd_lo;
  logic               finish;
  probe_res_e         fin_code;

  assign rd_lo = rd_data[7:0];

  // next-state and control decisions
  always_comb begin
    st_d     = st_q;
    wcnt_d   = wcnt_q;
    mid_d    = mid_q;
    tmr_clr  = 1'b0;
    tmr_pend = 1'b0;
    cap_clr  = 1'b0;
    cap_en   = 1'b0;
    finish   = 1'b0;
    fin_code = RES_FAIL;
    unique case (st_q)
      PS_IDLE: if (start) begin
        st_d    = PS_WSEL;
        cap_clr = 1'b1;
      end
      PS_WSEL: st_d = PS_WCMD;
      PS_WCMD: st_d = PS_RST0;
      PS_RST0: st_d = PS_CST0;
      PS_CST0: begin
        if (rd_lo == 8'h00) begin
          finish   = 1'b1;
          fin_code = RES_NONE;
        end else begin
          tmr_clr = 1'b1;
          st_d    = PS_RBSY;
        end
      end
      PS_RBSY: st_d = PS_CBSY;
      PS_CBSY: begin
        if (rd_lo[STB_BUSY]) begin
          tmr_pend = 1'b1;
          if (tmr_expire) finish = 1'b1;
          else            st_d   = PS_RBSY;
        end else begin
          st_d = PS_RMID;
        end
      end
      PS_RMID: st_d = PS_CMID;
      PS_CMID: begin
        mid_d = rd_lo;
        st_d  = PS_RHI;
      end
      PS_RHI: st_d = PS_CHI;
      PS_CHI: begin
        if ((mid_q != 8'h00) || (rd_lo != 8'h00)) begin
          finish = 1'b1;
          if ((mid_q == SIG_PKT_MID) && (rd_lo == SIG_PKT_HI))      fin_code = RES_PKT;
          else if ((mid_q == SIG_SER_MID) && (rd_lo == SIG_SER_HI)) fin_code = RES_SER;
          else                                                       fin_code = RES_FAIL;
        end else begin
          tmr_clr = 1'b1;
          st_d    = PS_RDRQ;
        end
      end
      PS_RDRQ: st_d = PS_CDRQ;
      PS_CDRQ: begin
        if (!rd_lo[STB_BUSY] && rd_lo[STB_FAIL]) begin
          finish = 1'b1;
        end else if (!rd_lo[STB_BUSY] && rd_lo[STB_DREQ]) begin
          wcnt_d = '0;
          st_d   = PS_RDAT;
        end else begin
          tmr_pend = 1'b1;
          if (tmr_expire) finish = 1'b1;
          else            st_d   = PS_RDRQ;
        end
      end
      PS_RDAT: st_d = PS_CDAT;
      PS_CDAT: begin
        cap_en = 1'b1;
        if (wcnt_q == LAST_WORD) begin
          finish   = 1'b1;
          fin_code = RES_ATA;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
          st_d   = PS_RDAT;
        end
      end
      default: st_d = PS_IDLE;
    endcase
    if (finish) st_d = PS_IDLE;
    done_d = finish;
    res_d  = finish ? fin_code : res_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      res_q  <= RES_NONE;
      done_q <= 1'b0;
      wcnt_q <= '0;
      mid_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (finish) res_q <= res_d;
      if (st_q == PS_CDRQ || st_q == PS_CDAT) wcnt_q <= wcnt_d;
      if (st_q == PS_CMID) mid_q <= mid_d;
    end
  end

  // bus drive decoded from the state register
  always_comb begin
    reg_idx = RIX_DATA;
    rd_stb  = 1'b0;
    wr_stb  = 1'b0;
    wr_data = '0;
    unique case (st_q)
      PS_WSEL: begin
        wr_stb  = 1'b1;
        reg_idx = RIX_DRVSEL;
        wr_data = {8'h00, DRVSEL_BASE | {3'b000, drive_sel, 4'h0}};
      end
      PS_WCMD: begin
        wr_stb  = 1'b1;
        reg_idx = RIX_CMDST;
        wr_data = {8'h00, CMD_IDENT};
      end
      PS_RST0, PS_RBSY, PS_RDRQ: begin
        rd_stb  = 1'b1;
        reg_idx = RIX_CMDST;
      end
      PS_RMID: begin
        rd_stb  = 1'b1;
        reg_idx = RIX_SIGMID;
      end
      PS_RHI: begin
        rd_stb  = 1'b1;
        reg_idx = RIX_SIGHI;
      end
      PS_RDAT: begin
        rd_stb  = 1'b1;
        reg_idx = RIX_DATA;
      end
      default: ;
    endcase
  end

  assign cap_idx = wcnt_q;
  assign done    = done_q;
  assign result  = res_q;
endmodule

// File: rtl/ata_probe_ctrl.sv
module ata_probe_ctrl
  import ata_probe_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          drive_sel,
  input  logic [TW-1:0] timeout_lim,
  output logic [2:0]    reg_idx,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [15:0]   wr_data,
  input  logic [15:0]   rd_data,
  output logic          done,
  output logic [2:0]    result,
  output logic          lba28_ok,
  output logic [31:0]   lba28_sectors,
  output logic          lba48_ok,
  output logic [63:0]   lba48_sectors
);
  logic              rst_n_sync;
  logic              tmr_clr, tmr_pend, tmr_expire;
  logic              cap_clr, cap_en;
  logic [WIDX_W-1:0] cap_idx;

  ata_probe_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_sync)
  );

  ata_probe_seq u_seq (
    .clk(clk), .rst_n(rst_n_sync), .start(start), .drive_sel(drive_sel),
    .rd_data(rd_data), .reg_idx(reg_idx), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .tmr_clr(tmr_clr), .tmr_pend(tmr_pend),
    .tmr_expire(tmr_expire), .cap_clr(cap_clr), .cap_en(cap_en),
    .cap_idx(cap_idx), .done(done), .result(result)
  );

  ata_probe_timer #(.CW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n_sync), .clr(tmr_clr), .pend(tmr_pend),
    .lim(timeout_lim), .expire(tmr_expire)
  );

  ata_probe_idcap u_cap (
    .clk(clk), .rst_n(rst_n_sync), .clr(cap_clr), .cap_en(cap_en),
    .cap_idx(cap_idx), .cap_word(rd_data), .lba28_ok(lba28_ok),
    .lba28_sectors(lba28_sectors), .lba48_ok(lba48_ok),
    .lba48_sectors(lba48_sectors)
  );
endmodule

// File: rtl/ata_probe_chk.sv
module ata_probe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic [2:0] reg_idx,
  input logic       done,
  input logic [2:0] result
);
  logic [9:0] dat_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        dat_cnt_q <= '0;
    else if (done)                     dat_cnt_q <= '0;
    else if (rd_stb && reg_idx == 3'd0) dat_cnt_q <= dat_cnt_q + 10'd1;
  end

  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  assert_write_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (reg_idx == 3'd6 || reg_idx == 3'd7));

  assert_burst_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dat_cnt_q <= 10'd256);

  assert_ata_words_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 3'd1) |-> dat_cnt_q == 10'd256);

  assert_no_data_other_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != 3'd1) |-> dat_cnt_q == 10'd0);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_stb && !wr_stb));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  assert_result_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result <= 3'd4);
endmodule

bind ata_probe_ctrl ata_probe_chk u_chk (
  .clk(clk), .rst_n(rst_n_sync), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .reg_idx(reg_idx), .done(done), .result(result)
);

// File: tb/ata_probe_ctrl_bench.sv
module ata_probe_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        drive_sel;
  logic [15:0] timeout_lim;
  logic [2:0]  reg_idx;
  logic        rd_stb, wr_stb;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        done;
  logic [2:0]  result;
  logic        lba28_ok, lba48_ok;
  logic [31:0] lba28_sectors;
  logic [63:0] lba48_sectors;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // device configuration
  bit       cfg_zero, cfg_abort, cfg_z28;
  int       cfg_bsy, cfg_drq;
  logic [7:0]  cfg_mid, cfg_hi;
  logic [15:0] cfg_seed;

  // device model observations
  int          m_st, m_drqn, m_dptr, m_nwr;
  bit          m_after;
  logic [2:0]  m_w0_idx, m_w1_idx;
  logic [15:0] m_w0_dat, m_w1_dat;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_probe_ctrl u_ata_probe_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .drive_sel(drive_sel),
    .timeout_lim(timeout_lim), .reg_idx(reg_idx), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data), .done(done),
    .result(result), .lba28_ok(lba28_ok), .lba28_sectors(lba28_sectors),
    .lba48_ok(lba48_ok), .lba48_sectors(lba48_sectors)
  );

  function automatic logic [15:0] idw(int i);
    logic [31:0] h;
    if (cfg_z28 && (i == 60 || i == 61)) return 16'h0000;
    h = (i * 32'h9E3779B1) ^ ({16'h0, cfg_seed} * 32'h0001_03B1);
    return h[23:8] ^ h[31:16];
  endfunction

  function automatic logic [7:0] stat_val(int n, bit after, int k);
    if (cfg_zero) return 8'h00;
    if (!after) return (n <= cfg_bsy) ? 8'h80 : (cfg_abort ? 8'h51 : 8'h50);
    if (k <= cfg_drq) return 8'h50;
    return cfg_abort ? 8'h51 : 8'h58;
  endfunction

  // behavioural register-file device
  always @(posedge clk) begin
    if (start) begin
      m_st <= 0; m_drqn <= 0; m_dptr <= 0; m_nwr <= 0; m_after <= 1'b0;
    end else begin
      if (wr_stb) begin
        m_nwr <= m_nwr + 1;
        if (m_nwr == 0) begin m_w0_idx <= reg_idx; m_w0_dat <= wr_data; end
        if (m_nwr == 1) begin m_w1_idx <= reg_idx; m_w1_dat <= wr_data; end
      end
      if (rd_stb) begin
        case (reg_idx)
          3'd7: begin
            m_st <= m_st + 1;
            if (m_after) m_drqn <= m_drqn + 1;
            rd_data <= {8'h00, stat_val(m_st + 1, m_after, m_drqn + 1)};
          end
          3'd4: rd_data <= {8'h00, cfg_mid};
          3'd5: begin rd_data <= {8'h00, cfg_hi}; m_after <= 1'b1; end
          3'd0: begin rd_data <= idw(m_dptr); m_dptr <= m_dptr + 1; end
          default: rd_data <= 16'h0000;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected fewer)", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int lim_eff(int lim);
    return (lim < 1) ? 1 : lim;
  endfunction

  function automatic int exp_res(int lim);
    int l = lim_eff(lim);
    if (cfg_zero) return 0;
    if (cfg_bsy >= l + 1) return 4;
    if (cfg_mid != 0 || cfg_hi != 0) begin
      if (cfg_mid == 8'h14 && cfg_hi == 8'hEB) return 2;
      if (cfg_mid == 8'h3C && cfg_hi == 8'hC3) return 3;
      return 4;
    end
    if (cfg_drq >= l) return 4;
    return cfg_abort ? 4 : 1;
  endfunction

  task automatic set_cfg(bit z, int b, int d, logic [7:0] mid, logic [7:0] hi,
                         bit ab, bit z28, logic [15:0] sd);
    cfg_zero = z; cfg_bsy = b; cfg_drq = d; cfg_mid = mid; cfg_hi = hi;
    cfg_abort = ab; cfg_z28 = z28; cfg_seed = sd;
  endtask

  task automatic run_case(input int lim, input bit ds, input string req);
    int exp, l, wait_n;
    bit got;
    logic [31:0] e28;
    logic [63:0] e48;
    l = lim_eff(lim);
    exp = exp_res(lim);
    @(negedge clk);
    timeout_lim = 16'(lim);
    drive_sel = ds;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 1'b0;
    for (int c = 0; c < 6000 && !got; c++) begin
      if (done) got = 1'b1;
      else @(negedge clk);
    end
    chk(got, req, "done seen", 64'(got), 64'd1);
    if (!got) return;
    chk(result == 3'(exp), req, "result code", 64'(result), 64'(exp));
    // R1 write sequence
    chk(m_nwr == 2 && m_w0_idx == 3'd6 && m_w1_idx == 3'd7, "R1", "write targets",
        {m_w0_idx, m_w1_idx, 8'(m_nwr)}, {3'd6, 3'd7, 8'd2});
    chk(m_w0_dat == (16'h00A0 | (16'(ds) << 4)) && m_w1_dat == 16'h00EC, "R1",
        "write data", {m_w0_dat, m_w1_dat}, {16'h00A0 | (16'(ds) << 4), 16'h00EC});
    if (cfg_zero) begin
      chk(m_st == 1 && m_dptr == 0 && !m_after, "R2", "accesses after zero status",
          64'(m_st), 64'd1);
    end else if (cfg_bsy >= l + 1) begin
      chk(m_st == l + 1 && !m_after, "R9", "busy-loop status reads", 64'(m_st), 64'(l + 1));
    end else begin
      int bs = (cfg_bsy < 1) ? 1 : cfg_bsy;
      chk(m_st - m_drqn == bs + 1, "R3", "busy-phase status reads",
          64'(m_st - m_drqn), 64'(bs + 1));
      if (cfg_mid != 0 || cfg_hi != 0) begin
        chk(m_drqn == 0 && m_dptr == 0, "R4", "reads after signature",
            64'(m_drqn + m_dptr), 64'd0);
      end else if (cfg_drq >= l) begin
        chk(m_drqn == l && m_dptr == 0, "R9", "data-request loop reads", 64'(m_drqn), 64'(l));
      end else begin
        chk(m_drqn == cfg_drq + 1, "R5", "data-request loop reads",
            64'(m_drqn), 64'(cfg_drq + 1));
        if (!cfg_abort) chk(m_dptr == 256, "R6", "data word reads", 64'(m_dptr), 64'd256);
        else            chk(m_dptr == 0, "R5", "data reads after error", 64'(m_dptr), 64'd0);
      end
    end
    if (exp == 1) begin
      e28 = {idw(61), idw(60)};
      e48 = {idw(103), idw(102), idw(101), idw(100)};
      chk(lba28_sectors == e28, "R7", "28-bit count", 64'(lba28_sectors), 64'(e28));
      chk(lba28_ok == (e28 != 0), "R7", "28-bit flag", 64'(lba28_ok), 64'(e28 != 0));
      chk(lba48_sectors == e48, "R8", "48-bit count", lba48_sectors, e48);
      chk(lba48_ok == idw(83)[10], "R8", "48-bit flag", 64'(lba48_ok), 64'(idw(83)[10]));
    end else begin
      chk(lba28_sectors == 0 && lba48_sectors == 0 && !lba28_ok && !lba48_ok, "R10",
          "fields cleared", lba48_sectors | 64'(lba28_sectors), 64'd0);
    end
    @(negedge clk);
    chk(!done, "R10", "done one cycle", 64'(done), 64'd0);
    chk(result == 3'(exp), "R10", "result held", 64'(result), 64'(exp));
    wait_n = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; drive_sel = 1'b0; timeout_lim = 16'd8;
    set_cfg(0, 0, 0, 8'h00, 8'h00, 0, 0, 16'h0);
    repeat (3) @(negedge clk);
    chk(!done && result == 0 && !rd_stb && !wr_stb, "R11", "reset outputs",
        {59'd0, done, rd_stb, wr_stb, 2'd0} | 64'(result), 64'd0);
    chk(lba28_sectors == 0 && lba48_sectors == 0 && !lba28_ok && !lba48_ok, "R11",
        "reset fields", lba48_sectors | 64'(lba28_sectors), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !rd_stb && !wr_stb, "R11", "idle after release",
        {61'd0, done, rd_stb, wr_stb}, 64'd0);

    // directed corners
    set_cfg(1, 0, 0, 8'h00, 8'h00, 0, 0, 16'h1111); run_case(8, 0, "R2");
    set_cfg(0, 3, 2, 8'h00, 8'h00, 0, 0, 16'h2222); run_case(10, 0, "R6");
    set_cfg(0, 2, 0, 8'h14, 8'hEB, 0, 0, 16'h3333); run_case(10, 0, "R4");
    set_cfg(0, 1, 0, 8'h3C, 8'hC3, 1, 0, 16'h4444); run_case(10, 1, "R4");
    set_cfg(0, 2, 1, 8'h00, 8'h00, 1, 0, 16'h5555); run_case(10, 0, "R5");
    set_cfg(0, 2, 1, 8'h22, 8'h00, 0, 0, 16'h6666); run_case(10, 0, "R4");
    set_cfg(0, 5, 0, 8'h00, 8'h00, 0, 0, 16'h7777); run_case(5, 0, "R9");
    set_cfg(0, 6, 0, 8'h00, 8'h00, 0, 0, 16'h7777); run_case(5, 0, "R9");
    set_cfg(0, 0, 3, 8'h00, 8'h00, 0, 0, 16'h8888); run_case(4, 1, "R9");
    set_cfg(0, 0, 4, 8'h00, 8'h00, 0, 0, 16'h8888); run_case(4, 1, "R9");
    set_cfg(0, 1, 0, 8'h00, 8'h00, 0, 0, 16'h9999); run_case(0, 0, "R9");
    set_cfg(0, 2, 0, 8'h00, 8'h00, 0, 0, 16'h9999); run_case(0, 0, "R9");
    set_cfg(0, 0, 0, 8'h00, 8'h00, 0, 1, 16'hAAAA); run_case(3, 1, "R7");

    // constrained random
    for (int n = 0; n < 40; n++) begin
      int kind = int'($urandom % 6);
      logic [7:0] mid = 8'h00, hi = 8'h00;
      bit ab = 1'($urandom);
      if (kind == 2) begin mid = 8'h14; hi = 8'hEB; end
      if (kind == 3) begin mid = 8'h3C; hi = 8'hC3; end
      if (kind == 5) begin mid = 8'($urandom); hi = 8'($urandom | 1); end
      if (kind == 1) ab = 1'b0;
      if (kind == 4) ab = 1'b1;
      set_cfg(kind == 0, int'($urandom % 8), int'($urandom % 6), mid, hi, ab,
              ($urandom % 8) == 0, 16'($urandom));
      run_case(1 + int'($urandom % 8), 1'($urandom), "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule